// File: doc/BRIEF.md
# Hub Status Change Bitmap Responder

This block keeps one sticky change flag for the hub and one for each of its downstream ports. A one-cycle event pulse on a source sets that source's flag. The flag stays set until the host sends a clear-feature request that names that source. The flags form a status byte: bit 0 is the hub itself, bits 1 to 4 are ports 1 to 4, and the upper bits are always zero.

When the host polls the hub's interrupt status endpoint, an IN token strobe arrives. On the next cycle the block answers with a response strobe and a kind flag. A data answer carries the whole status byte. A NAK is given when every flag is clear, and also when the device has not yet been configured.

Events that arrive before configuration are still latched, so they are reported once the configured flag rises. Packet encoding, CRC and the serial engine sit outside the block and turn the response into bus traffic.

Top module: `hub_chg_responder`

## Requirements
- R1: Status byte bit 0 reflects a change on the hub itself, and bit k (k = 1..4) reflects a change on port k. An event pulse on `chg_evt[j]` sets bit j.
- R2: Bits 7..5 of `resp_byte` are always 0.
- R3: A poll answered while the status byte is all zero returns `resp_valid`=1 with `resp_data`=0 (NAK) and `resp_byte`=0.
- R4: A poll while configured, with any of bits 4..0 set, returns `resp_data`=1 (data) and `resp_byte` equal to the whole status byte.
- R5: A set bit keeps being reported on every later poll until a clear request with `clr_idx` equal to its bit number arrives. That request clears only that bit.
- R6: While `cfg` is 0, every poll is answered with NAK. Events seen during that time stay latched and are reported after `cfg` rises.
- R7: When an event and a clear request for the same bit arrive in the same cycle, the bit ends up set.
- R8: `resp_valid` is high for exactly one cycle, namely the cycle after `in_tok` was high. The payload is the status byte as it stood at the token's clock edge, so events in that same cycle are not included.
- R9: A clear request for a bit that is already 0 changes nothing. A clear request with `clr_idx` of 5 or more is ignored.
- R10: Synchronous active-high `rst` clears all change bits and drives `resp_valid`, `resp_data` and `resp_byte` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chg_evt | input | 5 | Change event pulses: bit 0 is the hub, bits 1..4 are the ports |
| clr_req | input | 1 | Clear-feature request pulse |
| clr_idx | input | 3 | Source number of the bit to clear |
| cfg | input | 1 | Device configured flag |
| in_tok | input | 1 | IN token strobe for the status endpoint |
| resp_valid | output | 1 | Response strobe, one cycle after the token |
| resp_data | output | 1 | 1 means a data answer, 0 means NAK |
| resp_byte | output | 8 | Status byte payload, zero on NAK |

## Verification
The assertions assume that every input is synchronous to `clk` and that `clr_idx` matters only while `clr_req` is high. Beyond that they place no limit on input patterns: tokens may come back to back, and events, clears and tokens may all land in the same cycle. The stimulus keeps inputs changing only on the falling edge. It deliberately produces the overlapping cases the rules single out: an event and a clear for the same bit together, an event in the token's own cycle, clears with an index out of range, and `cfg` dropping and rising between polls.

// File: rtl/hub_chg_pkg.sv
package hub_chg_pkg;
   typedef enum logic {
      RESP_NAK  = 1'b0,
      RESP_DATA = 1'b1
   } resp_kind_e;
endpackage

// File: rtl/hub_chg_clr_dec.sv
// Turns a clear request and its source number into a one-hot clear mask.
// An index at or above NUM_SRC gives an empty mask.
module hub_chg_clr_dec #(
   parameter int NUM_SRC = 5,
   parameter int IDX_W   = 3
) (
   input  logic               clr_req,
   input  logic [IDX_W-1:0]   clr_idx,
   output logic [NUM_SRC-1:0] clr_mask
);
   always_comb begin
      clr_mask = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (clr_req && (clr_idx == IDX_W'(i))) clr_mask[i] = 1'b1;
      end
   end
endmodule

// File: rtl/hub_chg_cell.sv
// One sticky change flag. A set in the same cycle as a clear takes priority.
module hub_chg_cell (
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk) begin
      if (rst)        flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end
endmodule

// File: rtl/hub_chg_poll.sv
// Answers an IN token one cycle later with either a NAK or the status byte.
module hub_chg_poll
   import hub_chg_pkg::*;
#(
   parameter int NUM_SRC = 5,
   parameter int BYTE_W  = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tok_i,
   input  logic               cfg_i,
   input  logic [NUM_SRC-1:0] map_i,
   output logic               valid_o,
   output resp_kind_e         kind_o,
   output logic [BYTE_W-1:0]  byte_o
);
   localparam int PAD_W = BYTE_W - NUM_SRC;

   logic [BYTE_W-1:0] full_byte;
   logic              send_data;

   generate
      if (PAD_W > 0) begin : g_pad
         assign full_byte = {{PAD_W{1'b0}}, map_i};
      end else begin : g_nopad
         assign full_byte = map_i;
      end
   endgenerate

   assign send_data = tok_i && cfg_i && (|map_i);

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_o <= 1'b0;
         kind_o  <= RESP_NAK;
         byte_o  <= '0;
      end else begin
         valid_o <= tok_i;
         kind_o  <= send_data ? RESP_DATA : RESP_NAK;
         byte_o  <= send_data ? full_byte : '0;
      end
   end
endmodule

// File: rtl/hub_chg_responder.sv
module hub_chg_responder
   import hub_chg_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int BYTE_W    = 8,
   parameter int IDX_W     = 3
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_PORTS:0]   chg_evt,
   input  logic                 clr_req,
   input  logic [IDX_W-1:0]     clr_idx,
   input  logic                 cfg,
   input  logic                 in_tok,
   output logic                 resp_valid,
   output logic                 resp_data,
   output logic [BYTE_W-1:0]    resp_byte
);
   localparam int NUM_SRC = NUM_PORTS + 1;

   if (BYTE_W < NUM_SRC) begin : g_bad_width
      $error("status byte too narrow for the number of sources");
   end
   if ((1 << IDX_W) < NUM_SRC) begin : g_bad_idx
      $error("clear index too narrow for the number of sources");
   end

   logic [NUM_SRC-1:0] clr_mask;
   logic [NUM_SRC-1:0] chg_map;
   resp_kind_e         kind;

   hub_chg_clr_dec #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_dec (
      .clr_req  (clr_req),
      .clr_idx  (clr_idx),
      .clr_mask (clr_mask)
   );

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
      hub_chg_cell u_cell (
         .clk    (clk),
         .rst    (rst),
         .set_i  (chg_evt[g]),
         .clr_i  (clr_mask[g]),
         .flag_o (chg_map[g])
      );
   end

   hub_chg_poll #(.NUM_SRC(NUM_SRC), .BYTE_W(BYTE_W)) u_poll (
      .clk     (clk),
      .rst     (rst),
      .tok_i   (in_tok),
      .cfg_i   (cfg),
      .map_i   (chg_map),
      .valid_o (resp_valid),
      .kind_o  (kind),
      .byte_o  (resp_byte)
   );

   assign resp_data = (kind == RESP_DATA);
endmodule

// File: rtl/hub_chg_responder_chk.sv
module hub_chg_responder_chk #(
   parameter int NUM_SRC = 5,
   parameter int BYTE_W  = 8,
   parameter int IDX_W   = 3
) (
   input logic               clk,
   input logic               rst,
   input logic [NUM_SRC-1:0] chg_evt,
   input logic               clr_req,
   input logic [IDX_W-1:0]   clr_idx,
   input logic               cfg,
   input logic               in_tok,
   input logic [NUM_SRC-1:0] chg_map,
   input logic               resp_valid,
   input logic               resp_data,
   input logic [BYTE_W-1:0]  resp_byte
);
   // R8: a token is answered on the next cycle, and nothing else is
   a_r8_token_answered: assert property (@(posedge clk) disable iff (rst)
      in_tok |=> resp_valid);
   a_r8_no_stray_resp: assert property (@(posedge clk) disable iff (rst)
      !in_tok |=> !resp_valid);

   // R2: reserved bits stay zero
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
      resp_byte[BYTE_W-1:NUM_SRC] == '0);

   // R3: a NAK carries no payload
   a_r3_nak_empty: assert property (@(posedge clk) disable iff (rst)
      (resp_valid && !resp_data) |-> resp_byte == '0);

   // R6: before configuration every poll gets a NAK
   a_r6_unconfigured_nak: assert property (@(posedge clk) disable iff (rst)
      (in_tok && !cfg) |=> !resp_data);

   // R4: data payload equals the map as it stood at the token edge
   a_r4_payload_match: assert property (@(posedge clk) disable iff (rst)
      (in_tok && cfg && (|chg_map)) |=>
         (resp_data && resp_byte[NUM_SRC-1:0] == $past(chg_map)));

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      // R7: an event always leaves its bit set
      a_r7_event_sets: assert property (@(posedge clk) disable iff (rst)
         chg_evt[i] |=> chg_map[i]);
      // R5: a set bit survives anything but its own clear
      a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
         (chg_map[i] && !(clr_req && clr_idx == IDX_W'(i))) |=> chg_map[i]);
      // R9: no bit rises without its event
      a_r9_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
         (!chg_map[i] && !chg_evt[i]) |=> !chg_map[i]);
   end
endmodule

bind hub_chg_responder hub_chg_responder_chk #(
   .NUM_SRC (NUM_PORTS + 1),
   .BYTE_W  (BYTE_W),
   .IDX_W   (IDX_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .chg_evt    (chg_evt),
   .clr_req    (clr_req),
   .clr_idx    (clr_idx),
   .cfg        (cfg),
   .in_tok     (in_tok),
   .chg_map    (chg_map),
   .resp_valid (resp_valid),
   .resp_data  (resp_data),
   .resp_byte  (resp_byte)
);

// File: tb/hub_chg_responder_tb.sv
`timescale 1ns/1ps
module hub_chg_responder_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [4:0] chg_evt = '0;
   logic       clr_req = 1'b0;
   logic [2:0] clr_idx = '0;
   logic       cfg = 1'b0;
   logic       in_tok = 1'b0;
   logic       resp_valid;
   logic       resp_data;
   logic [7:0] resp_byte;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   hub_chg_responder u_dut (
      .clk(clk), .rst(rst), .chg_evt(chg_evt), .clr_req(clr_req),
      .clr_idx(clr_idx), .cfg(cfg), .in_tok(in_tok),
      .resp_valid(resp_valid), .resp_data(resp_data), .resp_byte(resp_byte)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model, compared on every clock
   int m_map = 0;
   int e_valid = 0, e_data = 0, e_byte = 0;
   always @(posedge clk) begin
      int s_evt, s_idx, clrm;
      bit s_tok, s_cfg, s_clr, s_rst;
      s_evt = int'(chg_evt); s_idx = int'(clr_idx);
      s_tok = in_tok; s_cfg = cfg; s_clr = clr_req; s_rst = rst;
      if (s_rst) begin
         m_map = 0; e_valid = 0; e_data = 0; e_byte = 0;
      end else begin
         e_valid = s_tok ? 1 : 0;
         if (s_tok && s_cfg && m_map != 0) begin
            e_data = 1; e_byte = m_map;
         end else begin
            e_data = 0; e_byte = 0;
         end
         clrm = (s_clr && s_idx < 5) ? (1 << s_idx) : 0;
         m_map = (m_map & ~clrm) | s_evt;
      end
      #1;
      if (s_rst) begin
         chk("R10 model valid", int'(resp_valid), 0);
         chk("R10 model byte", int'(resp_byte), 0);
      end else if (e_valid == 0) begin
         chk("R8 model valid", int'(resp_valid), 0);
      end else begin
         chk("R8 model valid", int'(resp_valid), 1);
         chk(e_data != 0 ? "R4 model kind" : "R3/R6 model kind", int'(resp_data), e_data);
         chk(e_data != 0 ? "R4 model byte" : "R3 model byte", int'(resp_byte), e_byte);
      end
   end

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic poll(input string tag, input int exp_data, input int exp_byte);
      in_tok = 1'b1;
      tick();
      in_tok = 1'b0;
      chk({tag, " valid"}, int'(resp_valid), 1);
      chk({tag, " kind"}, int'(resp_data), exp_data);
      chk({tag, " byte"}, int'(resp_byte), exp_byte);
   endtask

   task automatic clear(input int idx);
      clr_req = 1'b1;
      clr_idx = 3'(idx);
      tick();
      clr_req = 1'b0;
   endtask

   task automatic pulse(input int bits);
      chg_evt = 5'(bits);
      tick();
      chg_evt = '0;
   endtask

   initial begin
      #500us;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      repeat (3) tick();
      chk("R10 reset valid", int'(resp_valid), 0);
      chk("R10 reset byte", int'(resp_byte), 0);
      rst = 1'b0;
      tick();

      poll("R3 empty unconfigured", 0, 0);
      pulse(5'b00101);                       // hub and port 2
      poll("R6 unconfigured nak", 0, 0);
      cfg = 1'b1;
      poll("R6 latched then R1 mapping", 1, 8'h05);
      poll("R5 repeat", 1, 8'h05);
      clear(0);
      poll("R5 clear hub only", 1, 8'h04);
      clear(0);
      poll("R9 clear already zero", 1, 8'h04);
      clear(5);
      clear(7);
      poll("R9 out of range", 1, 8'h04);

      // R7: event and clear for port 3 in the same cycle
      chg_evt = 5'b01000; clr_req = 1'b1; clr_idx = 3'd3;
      tick();
      chg_evt = '0; clr_req = 1'b0;
      poll("R7 set wins", 1, 8'h0C);

      pulse(5'b10000);
      poll("R2 reserved zero with port 4", 1, 8'h1C);

      // R8: an event in the token cycle is not in that payload
      chg_evt = 5'b00010;
      poll("R8 payload sampled at token", 1, 8'h1C);
      chg_evt = '0;
      tick();
      chk("R8 single cycle strobe", int'(resp_valid), 0);
      poll("R8 next poll sees event", 1, 8'h1E);

      cfg = 1'b0;
      poll("R6 deconfigured nak", 0, 0);
      cfg = 1'b1;
      for (int k = 1; k <= 4; k++) clear(k);
      poll("R3 all cleared", 0, 0);

      pulse(5'b11111);
      rst = 1'b1;
      tick();
      rst = 1'b0;
      poll("R10 reset clears map", 0, 0);

      // mixed traffic checked by the reference model
      for (int n = 0; n < 4000; n++) begin
         chg_evt = (($urandom % 6) == 0) ? 5'($urandom) : 5'b0;
         clr_req = (($urandom % 3) == 0);
         clr_idx = 3'($urandom);
         in_tok  = (($urandom % 3) == 0);
         if (($urandom % 50) == 0) cfg = ~cfg;
         rst     = (($urandom % 500) == 0);
         tick();
      end
      chg_evt = '0; clr_req = 1'b0; in_tok = 1'b0; rst = 1'b0;
      tick();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule